// File: doc/BRIEF.md
# GPIO Input Qualification Filter

This block conditions a group of asynchronous pad inputs before core logic uses them. Each pin has its own 2-bit mode field. The field selects one of four paths: a plain two-flop synchronizer, a qualifier that needs 3 matching samples, a qualifier that needs 6 matching samples, or a raw bypass that skips all clocked logic. All pins share one sampling-period control value, so qualification can run on every clock or on a slower sample tick.

The qualified paths keep a short history of synchronized samples, taken on each sample tick. A pin's output moves to a new level only when the current sample and the required number of earlier samples all show that level. Any disagreement inside the window leaves the output where it was. In every mode except bypass the output comes straight from a register, so changing the mode or the period never produces a combinational glitch. The block has no data stream, so it has no valid/ready handshake; every pin is a plain level.

Top module: `gpio_input_qual`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, every pin output is 0, the sample history holds zeros and the tick counter is cleared.
- R2: The mode of pin p is `mode_i[2p+1:2p]`. With code 00 (the value expected after reset), `pin_o[p]` equals the level that `pad_i[p]` had three rising clock edges earlier (two synchronizer stages and one output register).
- R3: With code 01, `pin_o[p]` takes a new level on a sample tick only when the synchronized sample and the two samples taken on the previous ticks all show that level.
- R4: With code 10, `pin_o[p]` takes a new level on a sample tick only when the synchronized sample and the five samples taken on the previous ticks all show that level.
- R5: With code 11, `pin_o[p]` equals `pad_i[p]` combinationally, with no clock involved. In this mode the internal output register keeps tracking the synchronized level, as it does in code 00.
- R6: For a period value N on `period_i`, a sample tick occurs every 2·N clocks. N = 0 gives a tick on every clock.
- R7: In codes 01 and 10 the output holds its value on every clock with no tick, and on every tick whose sample window does not agree.
- R8: Mode and period can be changed at any time without a reset. A new period or qualified mode governs from the next sample tick, and outside bypass the output changes only at a rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| period_i | input | PER_W (8) | Sampling-period value N; ticks every 2·N clocks, every clock when 0 |
| mode_i | input | 2·PINS (8) | Per-pin mode field, pin p at bits [2p+1:2p] |
| pad_i | input | PINS (4) | Raw asynchronous pad levels |
| pin_o | output | PINS (4) | Conditioned pin levels |

## Verification
Each result has a fixed due time. In code 00 the output follows the pad three edges later. In code 11 it follows within the same cycle. In a qualified mode with N = 0, a new pad level that stays steady reaches the output on the fifth rising edge (code 01) or the eighth (code 10) after it is applied. Slower periods add their tick spacing. The bench changes inputs only just after a falling edge. Its reference model advances one step per rising edge, using the inputs held across that edge. The outputs are compared a moment after each falling edge, which is after the registers have settled and after the newly driven pad has reached the bypass path.

// File: rtl/gpq_pkg.sv
package gpq_pkg;
  typedef enum logic [1:0] {
    QM_SYNC  = 2'b00,
    QM_Q3    = 2'b01,
    QM_Q6    = 2'b10,
    QM_ASYNC = 2'b11
  } qmode_e;

  localparam int unsigned Q3_LEN = 3;
  localparam int unsigned Q6_LEN = 6;
  localparam int unsigned HIST_W = Q6_LEN - 1;
endpackage

// File: rtl/gpq_sync.sv
module gpq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpq_tick.sv
module gpq_tick #(
  parameter int unsigned PER_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] period_i,
  output logic             tick_o
);
  localparam int unsigned CNT_W = PER_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_c;

  always_comb begin
    last_c = {period_i, 1'b0} - CNT_W'(1);
    tick_o = (period_i == '0) || (cnt_q >= last_c);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CNT_W'(1);
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && period_i != '0) |=> (!tick_o || period_i == '0)); // R6
endmodule

// File: rtl/gpq_pin.sv
module gpq_pin
  import gpq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic [1:0] mode_i,
  input  logic       samp_i,
  input  logic       pad_i,
  output logic       out_o
);
  qmode_e            mode;
  logic [HIST_W-1:0] hist_q;
  logic              lvl_q;
  logic              win3_ok;
  logic              win6_ok;

  always_comb begin
    mode    = qmode_e'(mode_i);
    win3_ok = (hist_q[Q3_LEN-2:0] == {(Q3_LEN-1){samp_i}});
    win6_ok = (hist_q[Q6_LEN-2:0] == {(Q6_LEN-1){samp_i}});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      lvl_q  <= 1'b0;
    end else begin
      if (tick_i) hist_q <= {hist_q[HIST_W-2:0], samp_i};
      unique case (mode)
        QM_Q3:   if (tick_i && win3_ok) lvl_q <= samp_i;
        QM_Q6:   if (tick_i && win6_ok) lvl_q <= samp_i;
        default: lvl_q <= samp_i;
      endcase
    end
  end

  assign out_o = (mode == QM_ASYNC) ? pad_i : lvl_q;

  AST_SYNC_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b00 || mode_i == 2'b11) |=> (lvl_q == $past(samp_i))); // R2
  AST_Q3_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b01 && tick_i && $countones({hist_q[1:0], samp_i}) != 0
     && $countones({hist_q[1:0], samp_i}) != 3) |=> $stable(lvl_q)); // R3
  AST_Q6_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b10 && tick_i && $countones({hist_q, samp_i}) != 0
     && $countones({hist_q, samp_i}) != 6) |=> $stable(lvl_q)); // R4
  AST_HOLD_OFF_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_i == 2'b01 || mode_i == 2'b10) && !tick_i) |=> $stable(lvl_q)); // R7
endmodule

// File: rtl/gpio_input_qual.sv
module gpio_input_qual #(
  parameter int unsigned PINS        = 4,
  parameter int unsigned PER_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PER_W-1:0]   period_i,
  input  logic [2*PINS-1:0]  mode_i,
  input  logic [PINS-1:0]    pad_i,
  output logic [PINS-1:0]    pin_o
);
  logic            tick;
  logic [PINS-1:0] samp;

  gpq_tick #(.PER_W(PER_W)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .period_i (period_i),
    .tick_o   (tick)
  );

  for (genvar p = 0; p < PINS; p++) begin : g_pin
    gpq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pad_i[p]),
      .q_o   (samp[p])
    );

    gpq_pin u_pin (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick),
      .mode_i (mode_i[2*p+1:2*p]),
      .samp_i (samp[p]),
      .pad_i  (pad_i[p]),
      .out_o  (pin_o[p])
    );
  end
endmodule

// File: tb/sim_gpio_input_qual.sv
`timescale 1ns/1ps
module sim_gpio_input_qual;
  localparam int PINS = 4;
  localparam int WD_CYCLES = 20000;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [7:0]      per = '0;
  logic [1:0]      md [PINS];
  logic [2*PINS-1:0] mode_v;
  logic [PINS-1:0] pad = '0;
  logic [PINS-1:0] pin_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  string req = "R1";
  logic [15:0] lf = 16'hACE1;

  // behavioural reference state
  int cnt_m;
  bit s1m [PINS];
  bit s2m [PINS];
  bit qm  [PINS];
  bit hq  [PINS][$];

  always #2.5 clk = ~clk;

  always_comb
    for (int p = 0; p < PINS; p++) mode_v[2*p +: 2] = md[p];

  gpio_input_qual u0 (
    .clk(clk), .rst_n(rst_n), .period_i(per),
    .mode_i(mode_v), .pad_i(pad), .pin_o(pin_o)
  );

  function automatic logic [15:0] nxt(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  task automatic model_reset();
    cnt_m = 0;
    for (int p = 0; p < PINS; p++) begin
      s1m[p] = 0; s2m[p] = 0; qm[p] = 0;
      hq[p] = {};
      for (int i = 0; i < 5; i++) hq[p].push_back(1'b0);
    end
  endtask

  task automatic model_step();
    bit tk;
    tk = (per == 0) || (cnt_m >= 2 * int'(per) - 1);
    cnt_m = tk ? 0 : cnt_m + 1;
    for (int p = 0; p < PINS; p++) begin
      bit sm;
      sm = s2m[p];
      if (md[p] == 2'd0 || md[p] == 2'd3) qm[p] = sm;
      else if (tk) begin
        int need;
        bit ok;
        need = (md[p] == 2'd1) ? 2 : 5;
        ok = 1;
        for (int i = 0; i < need; i++) if (hq[p][i] != sm) ok = 0;
        if (ok) qm[p] = sm;
      end
      if (tk) begin
        hq[p].push_front(sm);
        void'(hq[p].pop_back());
      end
      s2m[p] = s1m[p];
      s1m[p] = pad[p];
    end
  endtask

  task automatic check(input bit ok, input string r, input logic [PINS-1:0] act,
                       input logic [PINS-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: pin_o actual=%b expected=%b at %0t", r, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [PINS-1:0] e;
    for (int p = 0; p < PINS; p++) e[p] = (md[p] == 2'd3) ? pad[p] : qm[p];
    check(pin_o === e, req, pin_o, e);
  endtask

  task automatic cyc(input logic [PINS-1:0] nv);
    @(posedge clk);
    model_step();
    @(negedge clk);
    pad = nv;
    #1 compare();
  endtask

  task automatic rnd_run(input int n, input int hold);
    for (int i = 0; i < n; i++) begin
      if (i % hold == 0) lf = nxt(lf);
      cyc(lf[PINS-1:0]);
    end
  endtask

  task automatic pulse(input int w, input int gap);
    for (int i = 0; i < w; i++) cyc({PINS{1'b1}});
    for (int i = 0; i < gap; i++) cyc('0);
  endtask

  task automatic set_modes(input logic [1:0] m);
    for (int p = 0; p < PINS; p++) md[p] = m;
  endtask

  initial begin
    set_modes(2'd0);
    model_reset();
    repeat (3) @(negedge clk);
    pad = '1;
    #1 check(pin_o === '0, "R1", pin_o, '0);  // R1 outputs zero under reset
    @(negedge clk);
    pad = '0;
    rst_n = 1'b1;
    #1 check(pin_o === '0, "R1", pin_o, '0);

    req = "R2"; rnd_run(40, 1);
    req = "R5"; set_modes(2'd3); rnd_run(20, 1);
    req = "R2"; set_modes(2'd0); rnd_run(10, 2);

    // 3-sample qualification, tick every clock
    req = "R3"; set_modes(2'd1); per = 8'd0;
    pulse(0, 8);
    req = "R7"; pulse(1, 8); pulse(2, 8);
    check(pin_o === '0, "R7", pin_o, '0);  // R7 short pulses filtered
    req = "R3"; pulse(3, 8); pulse(4, 10);

    // 6-sample qualification
    req = "R4"; set_modes(2'd2);
    pulse(5, 10);
    check(pin_o === '0, "R4", pin_o, '0);  // R4 five samples not enough
    pulse(6, 12); pulse(7, 12); rnd_run(40, 3);

    // sample period scaling
    req = "R6"; set_modes(2'd1); per = 8'd2; rnd_run(120, 7);
    per = 8'd1; set_modes(2'd2); rnd_run(100, 5);
    per = 8'd0; rnd_run(40, 4);

    // live changes of mode and period
    req = "R8";
    for (int k = 0; k < 25; k++) begin
      lf = nxt(lf);
      for (int p = 0; p < PINS; p++) md[p] = 2'(lf[2*p +: 2] % 3);
      per = {6'd0, lf[9:8]};
      rnd_run(7, 3);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule